// File: doc/BRIEF.md
# Double-Buffered PWM Duty Register Pair

This block holds the duty-cycle settings for one pair of motor-drive PWM channels. Each channel has a sign bit and an 11-bit duty value. A simple register port writes and reads them. A FAST input selects between two layouts for the data word. The normal layout carries the full 11-bit duty. The fast layout packs the sign and the middle seven duty bits into the upper byte, so one byte write is enough.

Written values land in shadow registers. The waveform generator never sees the shadow registers directly. It sees working copies, which are refreshed only at points where the change cannot produce a mixed waveform:

- continuously while the period is zero;
- continuously while a channel is switched off;
- on each counter overflow in the single-channel bridge modes;
- in dual full-bridge mode, only at the first overflow after the pair's odd (last) register has been written.

Reads always return the shadow contents in the current layout.

Top module: `pwm_duty_dbuf`

## Requirements
- R1: A write with `fast_mode`=0 stores bit 15 as the sign and bits 10..0 as the duty. Bits 14..11 of the write are ignored. A read with `fast_mode`=0 returns {sign, 4'b0000, duty}.
- R2: A write with `fast_mode`=1 stores bit 15 as the sign and bits 14..8 as duty bits 8..2. It clears duty bits 10, 9, 1 and 0 and ignores bits 7..0, so 0x5600 written fast stores the same duty as 0x0158 written normally.
- R3: A read with `fast_mode`=1 returns {sign, duty[8:2], 8'h00}. Changing `fast_mode` without a write leaves the stored value unchanged.
- R4: A read returns the most recently written shadow value of the addressed channel (`reg_addr` 0 or 1), not the working value.
- R5: While `period_zero`=1, each working register takes its channel's shadow value at every clock edge.
- R6: A channel whose 2-bit mode field is 0 (off) copies shadow to working at every clock edge, independently of the other channel.
- R7: With modes 1 (half-bridge) or 2 (full-bridge), a working register loads its shadow only at an edge where `ctr_ovf`=1, and holds otherwise.
- R8: When both mode fields are 3 (dual full-bridge), writing the odd register (`reg_addr`=1) arms the pair. The next `ctr_ovf` then loads both channels together and disarms the pair. An overflow while the pair is not armed loads nothing.
- R9: After reset, all shadow and working values, and every read, are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 1 | Channel select: 0 even, 1 odd |
| reg_wdata | input | 16 | Write data word |
| reg_rdata | output | 16 | Read data of the addressed shadow register |
| fast_mode | input | 1 | Selects the fast byte-wide layout for writes and reads |
| period_zero | input | 1 | High when the PWM period setting is zero |
| ch_mode | input | 4 | Two-bit mode per channel (channel 0 in bits 1..0): 0 off, 1 half, 2 full, 3 dual full |
| ctr_ovf | input | 1 | One-cycle PWM counter overflow strobe |
| work_duty | output | 22 | Working duty values, channel 0 in bits 10..0 |
| work_sign | output | 2 | Working sign bits, one per channel |

## Verification
The hardest condition to reach is the dual full-bridge rule. An overflow must be ignored until the odd register has been written, and then must move both channels at once. The stimulus starts from a state where the pair is disarmed, because every earlier odd write was consumed by a half-bridge overflow. It then writes only the even register and pulses an overflow, which must change nothing. After that it writes the odd register and waits an idle cycle before the overflow that moves both channels. A final even-only write followed by an overflow shows that the arm was consumed.

// File: rtl/pwm_duty_pkg.sv
package pwm_duty_pkg;

   localparam int unsigned MODE_W = 2;

   typedef enum logic [MODE_W-1:0] {
      MODE_OFF  = 2'd0,
      MODE_HALF = 2'd1,
      MODE_FULL = 2'd2,
      MODE_DUAL = 2'd3
   } chmode_e;

endpackage

// File: rtl/pwm_duty_xlate.sv
// Translates between bus words and the internal {sign, duty} form for both layouts.
module pwm_duty_xlate #(
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned DUTY_W  = 11,
   parameter int unsigned FAST_HI = 2,
   parameter int unsigned FAST_LO = 2
) (
   input  logic              fast,
   input  logic [DATA_W-1:0] wdata,
   output logic              wr_sign,
   output logic [DUTY_W-1:0] wr_duty,
   input  logic              rd_sign,
   input  logic [DUTY_W-1:0] rd_duty,
   output logic [DATA_W-1:0] rdata
);
   localparam int unsigned FAST_W = DUTY_W - FAST_HI - FAST_LO;
   localparam int unsigned FAST_TOP = DATA_W - 2;

   if (DUTY_W + 1 > DATA_W) begin : g_bad_width
      $error("duty plus sign does not fit the data word");
   end
   if (FAST_HI + FAST_LO >= DUTY_W) begin : g_bad_fast
      $error("fast layout leaves no duty bits");
   end
   if (FAST_W + 1 > DATA_W) begin : g_bad_fast_fit
      $error("fast field does not fit the data word");
   end

   always_comb begin
      wr_sign = wdata[DATA_W-1];
      wr_duty = '0;
      if (fast) begin
         wr_duty[FAST_LO +: FAST_W] = wdata[FAST_TOP -: FAST_W];
      end else begin
         wr_duty = wdata[DUTY_W-1:0];
      end
   end

   always_comb begin
      rdata = '0;
      rdata[DATA_W-1] = rd_sign;
      if (fast) begin
         rdata[FAST_TOP -: FAST_W] = rd_duty[FAST_LO +: FAST_W];
      end else begin
         rdata[DUTY_W-1:0] = rd_duty;
      end
   end

endmodule

// File: rtl/pwm_duty_slot.sv
// One channel: shadow register written from the bus, working register loaded on demand.
module pwm_duty_slot #(
   parameter int unsigned DUTY_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sign,
   input  logic [DUTY_W-1:0] wr_duty,
   input  logic              load,
   output logic              sh_sign,
   output logic [DUTY_W-1:0] sh_duty,
   output logic              wk_sign,
   output logic [DUTY_W-1:0] wk_duty
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_sign <= 1'b0;
         sh_duty <= '0;
      end else if (wr_en) begin
         sh_sign <= wr_sign;
         sh_duty <= wr_duty;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wk_sign <= 1'b0;
         wk_duty <= '0;
      end else if (load) begin
         wk_sign <= sh_sign;
         wk_duty <= sh_duty;
      end
   end

   // R5 / R6 / R7: a load request moves the pre-edge shadow contents
   p_load_copies_r5: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (wk_duty == $past(sh_duty)) && (wk_sign == $past(sh_sign)));

   // R7: without a load request the working value stays put
   p_hold_no_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(wk_duty) && $stable(wk_sign));

endmodule

// File: rtl/pwm_duty_xfer.sv
// Decides per channel when shadow moves to working; keeps the dual-pair arm flag.
module pwm_duty_xfer
   import pwm_duty_pkg::*;
#(
   parameter int unsigned NUM_CH = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     period_zero,
   input  logic [NUM_CH*MODE_W-1:0] ch_mode,
   input  logic                     ctr_ovf,
   input  logic                     odd_wr,
   output logic [NUM_CH-1:0]        load,
   output logic                     armed,
   output logic                     dual
);
   localparam int unsigned LAST = NUM_CH - 1;

   chmode_e           mode_v [NUM_CH];
   logic [NUM_CH-1:0] is_off;
   logic [NUM_CH-1:0] is_dual;
   logic              dual_fire;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign mode_v[c]  = chmode_e'(ch_mode[c*MODE_W +: MODE_W]);
      assign is_off[c]  = (mode_v[c] == MODE_OFF);
      assign is_dual[c] = (mode_v[c] == MODE_DUAL);
      assign load[c]    = period_zero || is_off[c] ||
                          (dual ? dual_fire : ctr_ovf);
   end

   assign dual      = &is_dual;
   assign dual_fire = ctr_ovf && armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
      end else if (odd_wr) begin
         armed <= 1'b1;
      end else if (load[LAST]) begin
         armed <= 1'b0;
      end
   end

   // R8: an odd-register write always leaves the pair armed
   p_arm_on_odd_r8: assert property (@(posedge clk) disable iff (!rst_n)
      odd_wr |=> armed);

   // R8: a completed transfer of the odd channel consumes the arm
   p_arm_consumed_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && load[LAST] && !odd_wr) |=> !armed);

endmodule

// File: rtl/pwm_duty_dbuf.sv
module pwm_duty_dbuf
   import pwm_duty_pkg::*;
#(
   parameter int unsigned NUM_CH  = 2,
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned DUTY_W  = 11,
   parameter int unsigned FAST_HI = 2,
   parameter int unsigned FAST_LO = 2,
   parameter int unsigned AW      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     reg_wr,
   input  logic [AW-1:0]            reg_addr,
   input  logic [DATA_W-1:0]        reg_wdata,
   output logic [DATA_W-1:0]        reg_rdata,
   input  logic                     fast_mode,
   input  logic                     period_zero,
   input  logic [NUM_CH*MODE_W-1:0] ch_mode,
   input  logic                     ctr_ovf,
   output logic [NUM_CH*DUTY_W-1:0] work_duty,
   output logic [NUM_CH-1:0]        work_sign
);
   localparam int unsigned FAST_W = DUTY_W - FAST_HI - FAST_LO;
   localparam logic [DUTY_W-1:0] FAST_KEEP =
      DUTY_W'(((1 << FAST_W) - 1) << FAST_LO);

   if (NUM_CH < 2) begin : g_bad_pair
      $error("a channel pair needs at least two channels");
   end
   if ((1 << AW) < NUM_CH) begin : g_bad_aw
      $error("address width too small for channel count");
   end

   logic                           wr_sign;
   logic [DUTY_W-1:0]              wr_duty;
   logic [NUM_CH-1:0]              sh_sign;
   logic [NUM_CH-1:0][DUTY_W-1:0]  sh_duty;
   logic [NUM_CH-1:0][DUTY_W-1:0]  wk_duty;
   logic [NUM_CH-1:0]              load;
   logic [NUM_CH-1:0]              wr_en;
   logic                           odd_wr;
   logic                           armed;
   logic                           dual;

   pwm_duty_xlate #(
      .DATA_W (DATA_W),
      .DUTY_W (DUTY_W),
      .FAST_HI(FAST_HI),
      .FAST_LO(FAST_LO)
   ) u_xlate (
      .fast   (fast_mode),
      .wdata  (reg_wdata),
      .wr_sign(wr_sign),
      .wr_duty(wr_duty),
      .rd_sign(sh_sign[reg_addr]),
      .rd_duty(sh_duty[reg_addr]),
      .rdata  (reg_rdata)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_slot
      assign wr_en[c] = reg_wr && (reg_addr == AW'(c));

      pwm_duty_slot #(.DUTY_W(DUTY_W)) u_slot (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_en  (wr_en[c]),
         .wr_sign(wr_sign),
         .wr_duty(wr_duty),
         .load   (load[c]),
         .sh_sign(sh_sign[c]),
         .sh_duty(sh_duty[c]),
         .wk_sign(work_sign[c]),
         .wk_duty(wk_duty[c])
      );

      assign work_duty[c*DUTY_W +: DUTY_W] = wk_duty[c];
   end

   assign odd_wr = wr_en[NUM_CH-1];

   pwm_duty_xfer #(.NUM_CH(NUM_CH)) u_xfer (
      .clk        (clk),
      .rst_n      (rst_n),
      .period_zero(period_zero),
      .ch_mode    (ch_mode),
      .ctr_ovf    (ctr_ovf),
      .odd_wr     (odd_wr),
      .load       (load),
      .armed      (armed),
      .dual       (dual)
   );

   // R2: a fast-layout write leaves the dropped duty bits cleared in the shadow
   p_fast_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && fast_mode) |=> ((sh_duty[$past(reg_addr)] & ~FAST_KEEP) == '0));

   // R8: a dual pair that is not armed ignores overflow
   p_dual_waits_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (dual && !period_zero && !armed) |=> $stable(work_duty) && $stable(work_sign));

   // R9: the working outputs are zero on the first edge after reset releases
   p_reset_zero_r9: assert property (@(posedge clk)
      !rst_n |=> (work_duty == '0) && (work_sign == '0));

endmodule

// File: tb/pwm_duty_dbuf_tb.sv
`timescale 1ns/1ps
module pwm_duty_dbuf_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [0:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        fast_mode = 1'b0;
   logic        period_zero = 1'b0;
   logic [3:0]  ch_mode = 4'b0101;
   logic        ctr_ovf = 1'b0;
   logic [21:0] work_duty;
   logic [1:0]  work_sign;

   int n_chk = 0;
   int n_err = 0;

   always #2.5 clk = ~clk;

   pwm_duty_dbuf dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fast_mode(fast_mode),
      .period_zero(period_zero), .ch_mode(ch_mode), .ctr_ovf(ctr_ovf),
      .work_duty(work_duty), .work_sign(work_sign)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [15:0] d, input logic f);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; fast_mode = f; reg_wr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      reg_wr = 1'b0; fast_mode = 1'b0;
   endtask

   task automatic rd(input logic a, input logic f, input logic [15:0] exp, input string tag);
      reg_addr = a; fast_mode = f;
      #1;
      chk(tag, 32'(reg_rdata), 32'(exp));
      fast_mode = 1'b0;
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic ovf();
      @(negedge clk);
      ctr_ovf = 1'b1;
      @(posedge clk);
      @(negedge clk);
      ctr_ovf = 1'b0;
   endtask

   task automatic work(input logic [10:0] d0, input logic s0,
                       input logic [10:0] d1, input logic s1, input string tag);
      chk({tag, " ch0 duty"}, 32'(work_duty[10:0]), 32'(d0));
      chk({tag, " ch0 sign"}, 32'(work_sign[0]), 32'(s0));
      chk({tag, " ch1 duty"}, 32'(work_duty[21:11]), 32'(d1));
      chk({tag, " ch1 sign"}, 32'(work_sign[1]), 32'(s1));
   endtask

   task automatic t_reset();
      work(11'h0, 1'b0, 11'h0, 1'b0, "R9 reset");
      rd(1'b0, 1'b0, 16'h0000, "R9 read ch0");
      rd(1'b1, 1'b0, 16'h0000, "R9 read ch1");
   endtask

   task automatic t_normal();
      wr(1'b0, 16'hFD55, 1'b0);
      rd(1'b0, 1'b0, 16'h8555, "R1 reserved bits dropped");
      work(11'h0, 1'b0, 11'h0, 1'b0, "R7 no ovf no load");
   endtask

   task automatic t_fast();
      wr(1'b1, 16'h5600, 1'b1);
      rd(1'b1, 1'b0, 16'h0158, "R2 fast 0x5600 equals 0x0158");
      wr(1'b1, 16'h07FF, 1'b0);
      wr(1'b1, 16'hFFAB, 1'b1);
      rd(1'b1, 1'b0, 16'h81FC, "R2 fast clears D10 D9 D1 D0, low byte ignored");
   endtask

   task automatic t_fast_read();
      rd(1'b0, 1'b1, 16'hD500, "R3 fast read layout");
      rd(1'b0, 1'b0, 16'h8555, "R3 fast toggle keeps value");
      rd(1'b1, 1'b1, 16'hFF00, "R3 fast read ch1");
   endtask

   task automatic t_half();
      ovf();
      work(11'h555, 1'b1, 11'h1FC, 1'b1, "R7 ovf loads");
      wr(1'b0, 16'h0001, 1'b0);
      tick();
      work(11'h555, 1'b1, 11'h1FC, 1'b1, "R7 hold without ovf");
      rd(1'b0, 1'b0, 16'h0001, "R4 read shadow not working");
      ovf();
      work(11'h001, 1'b0, 11'h1FC, 1'b1, "R7 second ovf");
   endtask

   task automatic t_period_zero();
      wr(1'b1, 16'h0300, 1'b0);
      period_zero = 1'b1;
      tick();
      work(11'h001, 1'b0, 11'h300, 1'b0, "R5 period zero copies");
      @(negedge clk);
      period_zero = 1'b0;
   endtask

   task automatic t_chan_off();
      ch_mode = 4'b0100;
      wr(1'b0, 16'h0222, 1'b0);
      wr(1'b1, 16'h0333, 1'b0);
      tick();
      work(11'h222, 1'b0, 11'h300, 1'b0, "R6 off channel copies, other holds");
      ovf();
      work(11'h222, 1'b0, 11'h333, 1'b0, "R6 enabled channel at ovf");
   endtask

   task automatic t_dual();
      ch_mode = 4'b1111;
      wr(1'b0, 16'h0123, 1'b0);
      ovf();
      work(11'h222, 1'b0, 11'h333, 1'b0, "R8 even write alone ignored");
      wr(1'b1, 16'h8456, 1'b0);
      tick();
      work(11'h222, 1'b0, 11'h333, 1'b0, "R8 armed waits for ovf");
      ovf();
      work(11'h123, 1'b0, 11'h456, 1'b1, "R8 pair loads together");
      wr(1'b0, 16'h0777, 1'b0);
      ovf();
      work(11'h123, 1'b0, 11'h456, 1'b1, "R8 arm consumed");
      wr(1'b1, 16'h0011, 1'b0);
      ovf();
      work(11'h777, 1'b0, 11'h011, 1'b0, "R8 rearmed pair loads");
   endtask

   initial begin
      #1_000_000;
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_normal();
      t_fast();
      t_fast_read();
      t_half();
      t_period_zero();
      t_chan_off();
      t_dual();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule